// File: doc/BRIEF.md
# Frequent-Value Compressed Cache Word Read Path

This block serves 32-bit word reads from a direct-mapped data cache whose data storage is shared. Every data slot is backed by two tag entries, so two compressed blocks can live in the storage of one. Each tag entry keeps a 4-bit descriptor for every word of its block. A descriptor marks the word either as compressed or as raw. A compressed word's value is held in a small table of common values, and the descriptor gives the table entry. A raw word is stored in the data slot, and the descriptor gives its offset there.

A read presents an index, a tag and a word select. Both tag entries paired with the indexed slot are compared with the request. On a hit the word's descriptor is taken from the matching entry. That descriptor steers the read to the value table or to the data slot. Words that come from the table never enable the data storage. Hit status, read data and a flag showing that the data storage was used all appear one cycle after the request.

The tag store, the data storage and the value table are loaded through simple write ports. These ports exist so that tests can build any cache image. Filling policy, eviction and stores are handled elsewhere.

Top module: `fvc_read_path`

## Requirements
- R1: After reset, and before any request, `rd_valid`, `rd_hit`, `slot_read` are 0 and `rd_data` is 0; all tag entries are invalid.
- R2: `rd_valid` is 1 in exactly the cycle after a cycle with `rd_req` high, and its results belong to that request; back-to-back requests give back-to-back results in order.
- R3: A request hits when either of the two tag entries paired with `rd_idx` (entry side 0 or side 1) is valid and its stored tag equals `rd_tag`.
- R4: On a miss, `rd_hit` is 0, `rd_data` is 0 and `slot_read` is 0.
- R5: On a hit to a word whose descriptor bit 3 is 1 (compressed), `rd_data` is the value-table entry selected by descriptor bits 2:0, and `slot_read` is 0 (the data storage is not enabled).
- R6: On a hit to a word whose descriptor bit 3 is 0 (raw), `rd_data` is the word at offset descriptor bits 2:0 of the indexed data slot, and `slot_read` is 1.
- R7: The descriptor of word w in a tag entry is `fill_desc[4*w+3 : 4*w]`, loaded together with the tag and valid bit.
- R8: A tag entry whose valid bit is 0 never hits, even if its stored tag equals the request tag.
- R9: In a cycle after one with no request, `rd_valid`, `slot_read` and `rd_data` are 0.
- R10: The two blocks sharing one data slot are read independently: each is served through its own descriptors from the same slot storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Word read request |
| rd_idx | input | IDX_W | Slot index of the request |
| rd_tag | input | TAG_W | Tag of the request |
| rd_wsel | input | WSEL_W | Word within the block |
| rd_valid | output | 1 | Result valid, one cycle after the request |
| rd_hit | output | 1 | Request hit one of the paired entries |
| rd_data | output | 32 | Word read; 0 on a miss |
| slot_read | output | 1 | Data storage was read for this result |
| fill_tag_en | input | 1 | Write one tag entry |
| fill_idx | input | IDX_W | Slot index for tag or data writes |
| fill_side | input | 1 | Which of the two paired entries to write |
| fill_valid | input | 1 | Valid bit to store |
| fill_tag | input | TAG_W | Tag to store |
| fill_desc | input | WORDS*4 | Descriptors for all words of the block |
| fill_data_en | input | 1 | Write one data slot word |
| fill_off | input | WSEL_W | Offset within the slot for the data write |
| fill_word | input | 32 | Data word to store |
| dict_wr_en | input | 1 | Write one value-table entry |
| dict_wr_sel | input | DSEL_W | Value-table entry to write |
| dict_wr_val | input | 32 | Value to store in the table |

## Verification
Every read result (hit, data and data-storage flag) is due in the cycle after the request is driven. So each request's expected result is queued when the request is driven on a falling edge. A monitor then compares the queued result shortly after the next rising edge, which is when the registered outputs settle. The monitor also flags a result that arrives with nothing queued, and a queued item that finds no result in that cycle. Idle-cycle and reset values are checked at the same post-edge point.

// File: rtl/fvc_pkg.sv
package fvc_pkg;
  localparam int WORD_W = 32;
  localparam int META_W = 3;
  localparam int DESC_W = META_W + 1;

  typedef struct packed {
    logic              comp;
    logic [META_W-1:0] meta;
  } desc_t;
endpackage

// File: rtl/fvc_tag_store.sv
module fvc_tag_store
  import fvc_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 8,
  parameter int WORDS = 8,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int ENTRIES = 2 * (1 << IDX_W),
  localparam int BLK_W = WORDS * DESC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_side,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [BLK_W-1:0]  wr_desc,
  input  logic              lk_req,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [WSEL_W-1:0] lk_wsel,
  output logic              hit,
  output desc_t             desc
);
  logic [ENTRIES-1:0] valid_r;
  logic [TAG_W-1:0]   tag_r  [ENTRIES];
  logic [BLK_W-1:0]   blk_r  [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_r <= '0;
    end else if (wr_en) begin
      valid_r[{wr_idx, wr_side}] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_r[{wr_idx, wr_side}] <= wr_tag;
      blk_r[{wr_idx, wr_side}] <= wr_desc;
    end
  end

  logic [1:0]       match;
  logic [BLK_W-1:0] side_blk [2];

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [IDX_W:0] ent;
    assign ent         = {lk_idx, (s == 1) ? 1'b1 : 1'b0};
    assign match[s]    = valid_r[ent] && (tag_r[ent] == lk_tag);
    assign side_blk[s] = blk_r[ent];
  end

  logic [BLK_W-1:0] sel_blk;
  assign hit     = |match;
  assign sel_blk = match[1] ? side_blk[1] : side_blk[0];
  assign desc    = desc_t'(sel_blk[lk_wsel * DESC_W +: DESC_W]);

  // R8: with both paired entries invalid, nothing may hit
  assert_invalid_no_hit_R8: assert property (@(posedge clk) disable iff (rst)
    (lk_req && !valid_r[{lk_idx, 1'b0}] && !valid_r[{lk_idx, 1'b1}]) |-> !hit);
endmodule

// File: rtl/fvc_dict.sv
module fvc_dict
  import fvc_pkg::*;
#(
  parameter int DICT_N = 8,
  localparam int DSEL_W = $clog2(DICT_N)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [DSEL_W-1:0] wr_sel,
  input  logic [WORD_W-1:0] wr_val,
  input  logic              rd_en,
  input  logic [DSEL_W-1:0] rd_sel,
  output logic [WORD_W-1:0] rd_q
);
  logic [WORD_W-1:0] val_r [DICT_N];

  always_ff @(posedge clk) begin
    if (wr_en) val_r[wr_sel] <= wr_val;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= val_r[rd_sel];
  end
endmodule

// File: rtl/fvc_slot_ram.sv
module fvc_slot_ram
  import fvc_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int WORDS = 8,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int DEPTH = (1 << IDX_W) * WORDS
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_off,
  input  logic [WORD_W-1:0] wr_val,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_off,
  output logic [WORD_W-1:0] rd_q
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_idx, wr_off}] <= wr_val;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[{rd_idx, rd_off}];
  end
endmodule

// File: rtl/fvc_read_path.sv
module fvc_read_path
  import fvc_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 8,
  parameter int WORDS = 8,
  parameter int DICT_N = 8,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int DSEL_W = $clog2(DICT_N)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_req,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic [TAG_W-1:0]        rd_tag,
  input  logic [WSEL_W-1:0]       rd_wsel,
  output logic                    rd_valid,
  output logic                    rd_hit,
  output logic [WORD_W-1:0]       rd_data,
  output logic                    slot_read,
  input  logic                    fill_tag_en,
  input  logic [IDX_W-1:0]        fill_idx,
  input  logic                    fill_side,
  input  logic                    fill_valid,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic [WORDS*DESC_W-1:0] fill_desc,
  input  logic                    fill_data_en,
  input  logic [WSEL_W-1:0]       fill_off,
  input  logic [WORD_W-1:0]       fill_word,
  input  logic                    dict_wr_en,
  input  logic [DSEL_W-1:0]       dict_wr_sel,
  input  logic [WORD_W-1:0]       dict_wr_val
);
  logic  lk_hit;
  desc_t lk_desc;

  fvc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WORDS(WORDS)) tags_i (
    .clk(clk), .rst(rst),
    .wr_en(fill_tag_en), .wr_idx(fill_idx), .wr_side(fill_side),
    .wr_valid(fill_valid), .wr_tag(fill_tag), .wr_desc(fill_desc),
    .lk_req(rd_req), .lk_idx(rd_idx), .lk_tag(rd_tag), .lk_wsel(rd_wsel),
    .hit(lk_hit), .desc(lk_desc)
  );

  logic ram_en, dict_en;
  assign ram_en  = rd_req && lk_hit && !lk_desc.comp;
  assign dict_en = rd_req && lk_hit &&  lk_desc.comp;

  logic [WORD_W-1:0] ram_q, dict_q;

  fvc_slot_ram #(.IDX_W(IDX_W), .WORDS(WORDS)) slots_i (
    .clk(clk),
    .wr_en(fill_data_en), .wr_idx(fill_idx), .wr_off(fill_off), .wr_val(fill_word),
    .rd_en(ram_en), .rd_idx(rd_idx), .rd_off(lk_desc.meta[WSEL_W-1:0]),
    .rd_q(ram_q)
  );

  fvc_dict #(.DICT_N(DICT_N)) dict_i (
    .clk(clk),
    .wr_en(dict_wr_en), .wr_sel(dict_wr_sel), .wr_val(dict_wr_val),
    .rd_en(dict_en), .rd_sel(lk_desc.meta[DSEL_W-1:0]),
    .rd_q(dict_q)
  );

  logic v_q, hit_q, comp_q, used_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      hit_q  <= 1'b0;
      comp_q <= 1'b0;
      used_q <= 1'b0;
    end else begin
      v_q    <= rd_req;
      hit_q  <= rd_req && lk_hit;
      comp_q <= lk_desc.comp;
      used_q <= ram_en;
    end
  end

  assign rd_valid  = v_q;
  assign rd_hit    = hit_q;
  assign slot_read = used_q;
  assign rd_data   = !hit_q ? '0 : (comp_q ? dict_q : ram_q);

  // R2: result appears exactly one cycle after a request
  assert_result_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  assert_no_result_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (!rd_valid && !slot_read && rd_data == '0));
  // R4: a miss returns zero and leaves the data storage alone
  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !lk_hit) |=> (rd_valid && !rd_hit && rd_data == '0 && !slot_read));
  // R5: compressed hits never enable the data storage
  assert_comp_skips_array_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_req && lk_hit && lk_desc.comp) |=> (rd_hit && !slot_read));
  // R6: raw hits read the data storage
  assert_raw_reads_array_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_req && lk_hit && !lk_desc.comp) |=> (rd_hit && slot_read));
endmodule

// File: tb/fvc_read_path_tb_top.sv
module fvc_read_path_tb_top;
  localparam int IDX_W = 3;
  localparam int TAG_W = 8;
  localparam int WORDS = 8;
  localparam int DICT_N = 8;
  localparam int SLOTS = 1 << IDX_W;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_req = 1'b0;
  logic [2:0]  rd_idx = '0;
  logic [7:0]  rd_tag = '0;
  logic [2:0]  rd_wsel = '0;
  logic        rd_valid, rd_hit, slot_read;
  logic [31:0] rd_data;
  logic        fill_tag_en = 1'b0;
  logic [2:0]  fill_idx = '0;
  logic        fill_side = 1'b0;
  logic        fill_valid = 1'b0;
  logic [7:0]  fill_tag = '0;
  logic [31:0] fill_desc = '0;
  logic        fill_data_en = 1'b0;
  logic [2:0]  fill_off = '0;
  logic [31:0] fill_word = '0;
  logic        dict_wr_en = 1'b0;
  logic [2:0]  dict_wr_sel = '0;
  logic [31:0] dict_wr_val = '0;

  always #5 clk = ~clk;

  fvc_read_path #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WORDS(WORDS), .DICT_N(DICT_N)) dut_i (
    .clk(clk), .rst(rst),
    .rd_req(rd_req), .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_wsel(rd_wsel),
    .rd_valid(rd_valid), .rd_hit(rd_hit), .rd_data(rd_data), .slot_read(slot_read),
    .fill_tag_en(fill_tag_en), .fill_idx(fill_idx), .fill_side(fill_side),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_desc(fill_desc),
    .fill_data_en(fill_data_en), .fill_off(fill_off), .fill_word(fill_word),
    .dict_wr_en(dict_wr_en), .dict_wr_sel(dict_wr_sel), .dict_wr_val(dict_wr_val)
  );

  typedef struct {
    logic        hit;
    logic [31:0] data;
    logic        used;
    int          req;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Bench model of the cache image, built from the requirements
  logic        m_valid [2*SLOTS];
  logic [7:0]  m_tag   [2*SLOTS];
  logic [31:0] m_desc  [2*SLOTS];
  logic [31:0] m_data  [SLOTS][WORDS];
  logic [31:0] m_dict  [DICT_N];

  function automatic exp_t predict(input logic [2:0] idx, input logic [7:0] tag,
                                   input logic [2:0] w);
    exp_t e;
    e.hit = 1'b0; e.data = '0; e.used = 1'b0; e.req = 4;
    for (int s = 0; s < 2; s++) begin
      int ent;
      ent = idx * 2 + s;
      // R3: either paired entry may match; R8: only when valid
      if (m_valid[ent] && m_tag[ent] == tag) begin
        logic [3:0] d;
        d = m_desc[ent][w*4 +: 4]; // R7 descriptor position
        e.hit = 1'b1;
        if (d[3]) begin e.data = m_dict[d[2:0]]; e.used = 1'b0; e.req = 5; end
        else      begin e.data = m_data[idx][d[2:0]]; e.used = 1'b1; e.req = 6; end
      end
    end
    return e;
  endfunction

  task automatic load_tag(input logic [2:0] idx, input logic side, input logic v,
                          input logic [7:0] tag, input logic [31:0] desc);
    @(negedge clk);
    fill_tag_en = 1'b1; fill_idx = idx; fill_side = side;
    fill_valid = v; fill_tag = tag; fill_desc = desc;
    m_valid[idx*2 + side] = v; m_tag[idx*2 + side] = tag; m_desc[idx*2 + side] = desc;
    @(negedge clk);
    fill_tag_en = 1'b0;
  endtask

  task automatic load_word(input logic [2:0] idx, input logic [2:0] off, input logic [31:0] val);
    @(negedge clk);
    fill_data_en = 1'b1; fill_idx = idx; fill_off = off; fill_word = val;
    m_data[idx][off] = val;
    @(negedge clk);
    fill_data_en = 1'b0;
  endtask

  task automatic load_dict(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk);
    dict_wr_en = 1'b1; dict_wr_sel = sel; dict_wr_val = val;
    m_dict[sel] = val;
    @(negedge clk);
    dict_wr_en = 1'b0;
  endtask

  // Driver: request on a falling edge, expected result queued at once
  task automatic issue(input logic [2:0] idx, input logic [7:0] tag, input logic [2:0] w);
    @(negedge clk);
    rd_req = 1'b1; rd_idx = idx; rd_tag = tag; rd_wsel = w;
    q.push_back(predict(idx, tag, w));
  endtask

  task automatic go_idle();
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  // Monitor: results due right after the rising edge following the request (R2)
  always begin
    @(posedge clk);
    #2;
    if (!rst && !done) begin
      if (rd_valid) begin
        total++;
        if (q.size() == 0) begin
          bad++;
          $display("FAIL R2: result with no request, act valid=%b exp none", rd_valid);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (rd_hit !== e.hit || rd_data !== e.data || slot_read !== e.used) begin
            bad++;
            $display("FAIL R%0d: act hit=%b data=%h used=%b exp hit=%b data=%h used=%b",
                     e.req, rd_hit, rd_data, slot_read, e.hit, e.data, e.used);
          end
        end
      end else if (q.size() != 0) begin
        total++;
        bad++;
        void'(q.pop_front());
        $display("FAIL R2: missing result, act valid=0 exp valid=1");
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: act running exp finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2*SLOTS; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = '0; m_desc[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #2;
    // R1: reset state
    total++;
    if (rd_valid !== 1'b0 || rd_hit !== 1'b0 || rd_data !== 32'h0 || slot_read !== 1'b0) begin
      bad++;
      $display("FAIL R1: act valid=%b hit=%b data=%h used=%b exp 0 0 0 0",
               rd_valid, rd_hit, rd_data, slot_read);
    end

    // R1: all entries start invalid, so any read misses (R4)
    issue(3'd2, 8'h11, 3'd0);
    go_idle();

    for (int i = 0; i < DICT_N; i++) load_dict(3'(i), 32'hF00D_0000 + i * 32'h1111);
    for (int s = 2; s <= 5; s += 3)
      for (int o = 0; o < WORDS; o++)
        load_word(3'(s), 3'(o), 32'hD000_0000 | (s << 8) | o);

    begin
      logic [31:0] da, db, dc;
      for (int w = 0; w < WORDS; w++) begin
        // R7: block A mixes compressed (even) and raw (odd) words
        da[w*4 +: 4] = (w % 2 == 0) ? {1'b1, 3'(w)} : {1'b0, 3'(w >> 1)};
        db[w*4 +: 4] = (w < 4) ? {1'b0, 3'(w + 4)} : {1'b1, 3'(7 - w)};
        dc[w*4 +: 4] = {1'b0, 3'(7 - w)};
      end
      load_tag(3'd2, 1'b0, 1'b1, 8'h11, da);
      load_tag(3'd2, 1'b1, 1'b1, 8'h22, db);   // R10: shares slot 2 with block A
      load_tag(3'd5, 1'b1, 1'b1, 8'h33, dc);
      load_tag(3'd5, 1'b0, 1'b0, 8'h44, 32'h0); // R8: invalid entry, tag 0x44
    end

    // R5/R6/R10: back-to-back reads of both blocks in slot 2 (R2 ordering)
    for (int w = 0; w < WORDS; w++) begin
      issue(3'd2, 8'h11, 3'(w));
      issue(3'd2, 8'h22, 3'(w));
    end
    // R3: hit through side 1 only
    for (int w = 0; w < WORDS; w++) issue(3'd5, 8'h33, 3'(w));
    issue(3'd5, 8'h44, 3'd0);   // R8
    issue(3'd0, 8'h11, 3'd1);   // R4: empty slot
    issue(3'd2, 8'h33, 3'd3);   // R3/R4: tag present elsewhere only
    go_idle();
    issue(3'd2, 8'h11, 3'd6);
    go_idle();
    @(negedge clk);
    @(posedge clk);
    #2;
    // R9: idle cycle gives no result
    total++;
    if (rd_valid !== 1'b0 || slot_read !== 1'b0 || rd_data !== 32'h0) begin
      bad++;
      $display("FAIL R9: act valid=%b used=%b data=%h exp 0 0 0", rd_valid, slot_read, rd_data);
    end
    repeat (2) @(negedge clk);
    done = 1'b1;
    if (q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R2: act pending=%0d exp pending=0", q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule